// File: doc/BRIEF.md
# Reference-Counted Pad Isolation Sequencer

This block owns the three isolation controls of a group of I/O pads: a core-supply-down flag, an early clamp and a main clamp. Several clients share the pads. Each client sends an enable request when it needs the pads and a disable request when it is done. The block counts how many clients are active. The pads stay isolated while the count is zero.

When the count rises from zero, the block lifts the isolation in three ordered steps. When the count falls back to zero, it puts the isolation back in three steps in the opposite order. A programmable settle interval separates the steps. While a sequence runs, the block holds off new requests. A force-off level drains every user and leaves the pads isolated. The block reports a disable with no users as an error, and it reports an enable that would exceed the user limit as an error.

Top module: `pad_clamp_seq`

## Requirements
- R1: An accepted enable with a count of zero sets the count to 1 and starts the release sequence. An accepted enable with a count between 1 and MAX_USERS-1 only adds one to the count and leaves the three controls unchanged.
- R2: The release sequence clears clamp_main at the accepting edge. It clears clamp_early S+1 cycles later and clamp_vcore another S+1 cycles after that, where S is the settle_cycles value.
- R3: An accepted disable with a count of one sets the count to 0 and starts the assert sequence. An accepted disable with a higher count only subtracts one.
- R4: The assert sequence sets clamp_vcore at the accepting edge, then clamp_early S+1 cycles later, then clamp_main another S+1 cycles after that.
- R5: An accepted disable with a count of zero changes neither the count nor the controls. In the next cycle err_unbalanced is high for exactly one cycle.
- R6: After reset the count is 0, all three controls are 1, busy is 0, req_ready is 1 and both error outputs are 0.
- R7: busy stays high from the accepting edge until 3*(S+1) cycles later. req_ready equals (not busy) and (not force_off). A request presented while req_ready is low has no effect.
- R8: status_word carries clamp_vcore at bit 31, clamp_early at bit 30 and clamp_main at bit 29. Every other bit of status_word is 0.
- R9: An accepted enable with a count of MAX_USERS leaves the count unchanged. In the next cycle err_overflow is high for one cycle.
- R10: While force_off is high and no sequence runs, the count drops by one each cycle. The step from one to zero starts the assert sequence, so the pads end isolated with a count of zero.
- R11: When en_req and dis_req are both high in an accepted cycle, the enable is taken and the disable is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Enable request from a client |
| dis_req | input | 1 | Disable request from a client |
| force_off | input | 1 | Level: drain all users and isolate the pads |
| settle_cycles | input | SETTLE_W | Extra cycles between steps (S) |
| req_ready | output | 1 | A request is accepted in this cycle |
| busy | output | 1 | A release or assert sequence is running |
| clamp_vcore | output | 1 | Core-supply-down flag |
| clamp_early | output | 1 | Early clamp enable |
| clamp_main | output | 1 | Main clamp enable |
| status_word | output | 32 | Control bits packed at bits 31..29 |
| user_count | output | CNT_W | Current number of active users |
| err_unbalanced | output | 1 | One-cycle pulse: disable with no users |
| err_overflow | output | 1 | One-cycle pulse: enable at the user limit |

## Verification
A wrong user count does not appear at the clamp outputs right away. It shows up on user_count in the cycle after the request. It also shows up much later as a sequence that starts on the wrong transition, or as an error pulse that should not fire. For this reason the count is compared on every clock along with the controls.

A wrong step index or settle timer shows up within one settle interval. A clamp then changes a cycle early or late, or out of order. These faults are caught on the first cycle that differs from the model.

// File: rtl/pad_clamp_pkg.sv
// Shared definitions for the pad isolation sequencer.
// Assumes exactly three isolation controls, held as one vector.
package pad_clamp_pkg;

    // Number of ordered steps in each sequence (one per control)
    localparam int NUM_STEPS = 3;

    // Bit positions inside the internal control vector
    localparam int IDX_MAIN  = 0;
    localparam int IDX_EARLY = 1;
    localparam int IDX_VCORE = 2;

    // Sequencer mode
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_RELEASE = 2'd1,
        SEQ_ASSERT  = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/pcs_user_count.sv
// Saturating count of active users.
// Assumes that inc and dec are never high in the same cycle (the top
// resolves priority).
module pcs_user_count #(
    parameter int MAX_USERS = 15,
    parameter int CNT_W     = $clog2(MAX_USERS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             at_zero,
    output logic             at_one,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] MAX_VAL = CNT_W'(MAX_USERS);
    localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

    // Register: add or subtract one user per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != MAX_VAL)
            count <= count + ONE_VAL;
        else if (dec && count != '0)
            count <= count - ONE_VAL;
    end

    // Decode: flags for the transitions the top cares about
    always_comb begin
        at_zero = (count == '0);
        at_one  = (count == ONE_VAL);
        at_max  = (count == MAX_VAL);
    end
endmodule

// File: rtl/pcs_settle_timer.sv
// Down-counter that spaces the steps of a sequence.
// After a load with value S it reports expiry S cycles later.
module pcs_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] settle_in,
    output logic                expired
);
    logic [SETTLE_W-1:0] remain;

    // Register: reload on a step, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= settle_in;
        else if (remain != '0)
            remain <= remain - SETTLE_W'(1);
    end

    // Decode: expiry when the remaining count is zero
    assign expired = (remain == '0);
endmodule

// File: rtl/pcs_step_fsm.sv
// Ordered release/assert stepper for the isolation control vector.
// Release clears bit 0, then 1, then 2. Assert sets bit 2, then 1, then 0.
// Assumes that a start request arrives only while idle.
module pcs_step_fsm
    import pad_clamp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_release,
    input  logic                 start_assert,
    input  logic                 tmr_expired,
    output logic                 busy,
    output logic                 tmr_load,
    output logic [NUM_STEPS-1:0] ctrl
);
    localparam int SW = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam logic [SW-1:0] LAST = SW'(NUM_STEPS - 1);

    seq_mode_e       mode;
    logic [SW-1:0]   step;
    logic [SW-1:0]   nxt_step;
    logic [SW-1:0]   rel_idx;
    logic [SW-1:0]   asr_idx;
    logic            advance;

    // Decode: next step and the bit it touches in each direction
    always_comb begin
        nxt_step = step + SW'(1);
        rel_idx  = nxt_step;
        asr_idx  = LAST - nxt_step;
        advance  = (mode != SEQ_IDLE) && tmr_expired && (step != LAST);
        busy     = (mode != SEQ_IDLE);
        tmr_load = ((mode == SEQ_IDLE) && (start_release || start_assert)) || advance;
    end

    // Register: mode, step index and control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= SEQ_IDLE;
            step <= '0;
            ctrl <= '1;
        end else begin
            case (mode)
                SEQ_IDLE: begin
                    if (start_release) begin
                        mode     <= SEQ_RELEASE;
                        step     <= '0;
                        ctrl[0]  <= 1'b0;
                    end else if (start_assert) begin
                        mode     <= SEQ_ASSERT;
                        step     <= '0;
                        ctrl[LAST] <= 1'b1;
                    end
                end
                default: begin
                    if (tmr_expired) begin
                        if (step == LAST) begin
                            mode <= SEQ_IDLE;
                        end else begin
                            step <= nxt_step;
                            if (mode == SEQ_RELEASE)
                                ctrl[rel_idx] <= 1'b0;
                            else
                                ctrl[asr_idx] <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pad_clamp_seq.sv
// Top: reference-counted pad isolation sequencer.
// Accepts one request per cycle while idle and force_off is low.
// Enable has priority over disable. force_off drains one user per cycle.
module pad_clamp_seq
    import pad_clamp_pkg::*;
#(
    parameter int MAX_USERS = 15,
    parameter int SETTLE_W  = 8,
    parameter int CNT_W     = $clog2(MAX_USERS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_req,
    input  logic                dis_req,
    input  logic                force_off,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                req_ready,
    output logic                busy,
    output logic                clamp_vcore,
    output logic                clamp_early,
    output logic                clamp_main,
    output logic [31:0]         status_word,
    output logic [CNT_W-1:0]    user_count,
    output logic                err_unbalanced,
    output logic                err_overflow
);
    logic at_zero, at_one, at_max;
    logic acc_en, acc_dis, acc_force;
    logic inc, dec, start_rel, start_asr;
    logic tmr_load, tmr_expired;
    logic [NUM_STEPS-1:0] ctrl;

    // Decode: request acceptance and sequence triggers
    always_comb begin
        req_ready = !busy && !force_off;
        acc_force = !busy && force_off && !at_zero;
        acc_en    = req_ready && en_req;
        acc_dis   = req_ready && !en_req && dis_req;
        inc       = acc_en && !at_max;
        dec       = acc_force || (acc_dis && !at_zero);
        start_rel = inc && at_zero;
        start_asr = dec && at_one;
    end

    // Register: one-cycle error pulses for misuse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_unbalanced <= 1'b0;
            err_overflow   <= 1'b0;
        end else begin
            err_unbalanced <= acc_dis && at_zero;
            err_overflow   <= acc_en && at_max;
        end
    end

    pcs_user_count #(.MAX_USERS(MAX_USERS), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
        .count(user_count), .at_zero(at_zero), .at_one(at_one), .at_max(at_max)
    );

    pcs_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .settle_in(settle_cycles), .expired(tmr_expired)
    );

    pcs_step_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_release(start_rel),
        .start_assert(start_asr), .tmr_expired(tmr_expired),
        .busy(busy), .tmr_load(tmr_load), .ctrl(ctrl)
    );

    // Decode: named outputs and the packed status word
    always_comb begin
        clamp_vcore = ctrl[IDX_VCORE];
        clamp_early = ctrl[IDX_EARLY];
        clamp_main  = ctrl[IDX_MAIN];
        status_word = {clamp_vcore, clamp_early, clamp_main, 29'd0};
    end
endmodule

// File: rtl/pad_clamp_seq_chk.sv
// Property checker for pad_clamp_seq, attached with bind below.
module pad_clamp_seq_chk #(
    parameter int MAX_USERS = 15,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_off,
    input logic             req_ready,
    input logic             busy,
    input logic             clamp_vcore,
    input logic             clamp_early,
    input logic             clamp_main,
    input logic [CNT_W-1:0] user_count,
    input logic             err_unbalanced,
    input logic             err_overflow
);
    // R1: release begins only on the zero-to-one transition
    p_first_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_main) |-> ($past(user_count) == '0 && user_count == CNT_W'(1)));

    // R1: the count moves by at most one per cycle
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (user_count != $past(user_count)) |->
        (user_count == $past(user_count) + CNT_W'(1) || user_count == $past(user_count) - CNT_W'(1)));

    // R2: early clamp drops only after main, while vcore is still high
    p_release_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_early) |-> (!clamp_main && clamp_vcore));

    // R2: vcore drops last
    p_release_vcore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_vcore) |-> (!clamp_main && !clamp_early));

    // R3: the assert sequence starts only when the count has reached zero
    p_last_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_vcore) |-> (user_count == '0));

    // R4: main clamp returns last
    p_assert_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_main) |-> (clamp_early && clamp_vcore));

    // R4: early clamp returns after vcore
    p_assert_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_early) |-> clamp_vcore);

    // R5: an unbalanced disable leaves the controls and the count untouched
    p_unbalanced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_unbalanced |-> (user_count == '0 && $stable(clamp_vcore) &&
                            $stable(clamp_early) && $stable(clamp_main)));

    // R7: no acceptance during a sequence or a forced drain
    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || force_off) |-> !req_ready);

    // R9: overflow reported only at the limit, count held
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> (user_count == CNT_W'(MAX_USERS) && $stable(user_count)));
endmodule

bind pad_clamp_seq pad_clamp_seq_chk #(.MAX_USERS(MAX_USERS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_off(force_off), .req_ready(req_ready),
    .busy(busy), .clamp_vcore(clamp_vcore), .clamp_early(clamp_early),
    .clamp_main(clamp_main), .user_count(user_count),
    .err_unbalanced(err_unbalanced), .err_overflow(err_overflow)
);

// File: tb/pad_clamp_seq_bench.sv
// Bench: behavioural cycle model compared on every clock, plus directed checks.
module pad_clamp_seq_bench;
    localparam int MAXU = 15;
    localparam int SW   = 8;
    localparam int CW   = $clog2(MAXU + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_req = 1'b0;
    logic          dis_req = 1'b0;
    logic          force_off = 1'b0;
    logic [SW-1:0] settle_cycles = 8'd2;
    logic          req_ready, busy, clamp_vcore, clamp_early, clamp_main;
    logic [31:0]   status_word;
    logic [CW-1:0] user_count;
    logic          err_unbalanced, err_overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit started  = 0;
    bit finished = 0;

    // model state
    int m_cnt = 0, m_state = 0, m_step = 0, m_timer = 0;
    int m_v = 1, m_e = 1, m_m = 1, m_eu = 0, m_eo = 0;

    always #4 clk = ~clk;

    pad_clamp_seq #(.MAX_USERS(MAXU), .SETTLE_W(SW)) u_pad_clamp_seq (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .force_off(force_off), .settle_cycles(settle_cycles),
        .req_ready(req_ready), .busy(busy), .clamp_vcore(clamp_vcore),
        .clamp_early(clamp_early), .clamp_main(clamp_main),
        .status_word(status_word), .user_count(user_count),
        .err_unbalanced(err_unbalanced), .err_overflow(err_overflow)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic apply_step(input int st, input int idx);
        if (st == 1) begin
            if (idx == 0) m_m = 0; else if (idx == 1) m_e = 0; else m_v = 0;
        end else begin
            if (idx == 0) m_v = 1; else if (idx == 1) m_e = 1; else m_m = 1;
        end
    endtask

    // reference model, one update per rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_state = 0; m_step = 0; m_timer = 0;
            m_v = 1; m_e = 1; m_m = 1; m_eu = 0; m_eo = 0;
        end else begin
            m_eu = 0; m_eo = 0;
            if (m_state == 0) begin
                if (force_off) begin
                    if (m_cnt > 0) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_state = 2; m_step = 0; m_timer = settle_cycles; apply_step(2, 0); end
                    end
                end else if (en_req) begin
                    if (m_cnt == MAXU) m_eo = 1;
                    else begin
                        if (m_cnt == 0) begin m_state = 1; m_step = 0; m_timer = settle_cycles; apply_step(1, 0); end
                        m_cnt++;
                    end
                end else if (dis_req) begin
                    if (m_cnt == 0) m_eu = 1;
                    else begin
                        if (m_cnt == 1) begin m_state = 2; m_step = 0; m_timer = settle_cycles; apply_step(2, 0); end
                        m_cnt--;
                    end
                end
            end else if (m_timer > 0) begin
                m_timer--;
            end else if (m_step < 2) begin
                m_step++;
                apply_step(m_state, m_step);
                m_timer = settle_cycles;
            end else begin
                m_state = 0;
            end
        end
    end

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R2/R4 clamp_main",  clamp_main,  m_m);
            check("R2/R4 clamp_early", clamp_early, m_e);
            check("R2/R4 clamp_vcore", clamp_vcore, m_v);
            check("R1/R3 user_count",  user_count,  m_cnt);
            check("R7 busy",           busy,        m_state != 0);
            check("R7 req_ready",      req_ready,   (m_state == 0) && !force_off);
            check("R5 err_unbalanced", err_unbalanced, m_eu);
            check("R9 err_overflow",   err_overflow,   m_eo);
            check("R8 status_word",    status_word, {m_v[0], m_e[0], m_m[0], 29'd0});
        end
    end

    task automatic req(input logic en, input logic dis);
        @(negedge clk); #1; en_req = en; dis_req = dis;
        @(negedge clk); #1; en_req = 1'b0; dis_req = 1'b0;
    endtask

    task automatic wait_idle;
        @(negedge clk); #1;
        while (busy) begin @(negedge clk); #1; end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R6: reset state
        check("R6 clamps", {clamp_vcore, clamp_early, clamp_main}, 3'b111);
        check("R6 count", user_count, 0);
        check("R6 ready", req_ready, 1);
        check("R8 status isolated", status_word, 32'hE000_0000);
        rst_n = 1'b1;

        // R5: disable with no users
        req(0, 1);
        check("R5 err pulse", err_unbalanced, 1);
        check("R5 clamps kept", {clamp_vcore, clamp_early, clamp_main}, 3'b111);

        // R1/R2: first enable releases
        req(1, 0);
        check("R1 count one", user_count, 1);
        check("R1 main first", {clamp_vcore, clamp_early, clamp_main}, 3'b110);
        wait_idle();
        check("R2 released", {clamp_vcore, clamp_early, clamp_main}, 3'b000);
        check("R8 status released", status_word, 32'h0);

        req(1, 0);
        check("R1 increment only", user_count, 2);
        check("R1 no sequence", busy, 0);

        // R11: both requests, enable wins
        req(1, 1);
        check("R11 enable priority", user_count, 3);

        req(0, 1);
        check("R3 decrement only", user_count, 2);
        check("R3 clamps kept", {clamp_vcore, clamp_early, clamp_main}, 3'b000);

        settle_cycles = 8'd0;
        req(0, 1);
        req(0, 1);
        check("R3 last disable", user_count, 0);
        // R7: request during a sequence ignored
        req(1, 0);
        wait_idle();
        check("R7 ignored while busy", user_count, 0);
        check("R4 isolated again", {clamp_vcore, clamp_early, clamp_main}, 3'b111);

        // R9: overflow at the limit
        settle_cycles = 8'd1;
        for (int i = 0; i < MAXU; i++) begin
            req(1, 0);
            wait_idle();
        end
        check("R9 at limit", user_count, MAXU);
        req(1, 0);
        check("R9 overflow pulse", err_overflow, 1);
        check("R9 count held", user_count, MAXU);

        // R10: forced drain
        settle_cycles = 8'd3;
        @(negedge clk); #1; force_off = 1'b1;
        en_req = 1'b1;
        @(negedge clk); #1;
        check("R7 ready low under force", req_ready, 0);
        en_req = 1'b0;
        while (user_count != 0 || busy) begin @(negedge clk); #1; end
        check("R10 drained", user_count, 0);
        check("R10 isolated", {clamp_vcore, clamp_early, clamp_main}, 3'b111);
        force_off = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule